// File: doc/BRIEF.md
# GPIO Set/Clear Output Controller

A general-purpose I/O block for a configurable number of pins (28 by default) that sits behind a small word-addressed register port. Software never has to read, modify and write back the output state. It drives pins high through one write-only register and low through a second one. In both, a one bit acts on its pin and a zero bit leaves that pin alone.

A readable and writable direction register marks each pin as output (1) or input (0). Set and clear writes take effect only on pins that are outputs at the time of the write. A hidden output latch holds the value that is driven. It keeps that value while a pin is an input, so turning a pin into an output drives whatever the latch last held. Each pin is presented to a tri-state pad as a data bit plus an enable bit, and the enable equals the direction bit.

Every pad level is brought back through a synchronizer into a read-only level register, whatever the pin's direction. Software can compare the live level with the value it last drove and so detect an external device fighting an output.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: While reset is active, and right after it, the direction register is zero, every pin's output enable is 0 and the output latch is all zeros.
- R2: A write to offset 0x4 loads the direction register (bit n set = pin n is an output). Reading offset 0x4 returns it, `pin_oe` always equals it, and it changes only on such a write.
- R3: A write to offset 0x8 makes `pin_out` go to 1 from the next cycle on every output pin whose write-data bit is 1.
- R4: A write to offset 0xC makes `pin_out` go to 0 from the next cycle on every output pin whose write-data bit is 1.
- R5: Write-data bits that are 0 in a set or clear write leave their pins' output values unchanged.
- R6: A set or clear write has no effect on a pin whose direction bit is 0, and its output latch value is kept.
- R7: Write-data bits above the pin count (bits 31..28 by default) are ignored by every register, and reads return 0 in them.
- R8: Offset 0x0 returns the pad inputs after a two-flop synchronizer: a pad change is visible to a read after exactly two rising clock edges, not after one. This holds for output pins too, so a pad that differs from the driven value can be seen.
- R9: When a pin is switched from input to output, it drives the value its output latch last held.
- R10: Reads of the write-only set (0x8) and clear (0xC) offsets return 0.
- R11: An access to any other offset changes no state, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Byte offset of the register being accessed |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 28 | Pad input levels, asynchronous |
| pin_out | output | 28 | Pad output data |
| pin_oe | output | 28 | Pad output enable, 1 = drive |

## Verification
The bench builds the block with its defaults: 28 pins on a 32-bit data bus, a 4-bit offset and a two-stage synchronizer. With these values the four reserved bits 31..28 are exercised on writes and on reads. The unused offsets between the four registers can also be reached. The synchronizer depth is fixed at two, so the bench can check the exact edge at which a pad change becomes readable. Driving output pins against opposing pad levels shows the conflict readback.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

   // Register byte offsets; the decode compares the full offset.
   localparam logic [3:0] OFS_LEVEL = 4'h0;
   localparam logic [3:0] OFS_DIR   = 4'h4;
   localparam logic [3:0] OFS_SET   = 4'h8;
   localparam logic [3:0] OFS_CLR   = 4'hC;

   // Write strobes, at most one set per cycle.
   typedef struct packed {
      logic dir;
      logic set;
      logic clr;
   } wr_stb_t;

   // Read source selection.
   typedef enum logic [1:0] {
      RSEL_NONE  = 2'd0,
      RSEL_LEVEL = 2'd1,
      RSEL_DIR   = 2'd2
   } rd_sel_e;

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
   import gpio_sc_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output wr_stb_t           stb,
   output rd_sel_e           rsel
);

   localparam int PAD_W = ADDR_W - 4;

   logic hit_level, hit_dir, hit_set, hit_clr;

   generate
      if (PAD_W > 0) begin : g_wide
         logic upper_zero;
         assign upper_zero = (addr[ADDR_W-1:4] == '0);
         assign hit_level  = upper_zero && (addr[3:0] == OFS_LEVEL);
         assign hit_dir    = upper_zero && (addr[3:0] == OFS_DIR);
         assign hit_set    = upper_zero && (addr[3:0] == OFS_SET);
         assign hit_clr    = upper_zero && (addr[3:0] == OFS_CLR);
      end else begin : g_narrow
         assign hit_level  = (addr == OFS_LEVEL);
         assign hit_dir    = (addr == OFS_DIR);
         assign hit_set    = (addr == OFS_SET);
         assign hit_clr    = (addr == OFS_CLR);
      end
   endgenerate

   always_comb begin
      stb.dir = wr && hit_dir;
      stb.set = wr && hit_set;
      stb.clr = wr && hit_clr;
   end

   always_comb begin
      if (hit_level)    rsel = RSEL_LEVEL;
      else if (hit_dir) rsel = RSEL_DIR;
      else              rsel = RSEL_NONE;
   end

endmodule

// File: rtl/gpio_sc_sync_bank.sv
module gpio_sc_sync_bank #(
   parameter int WIDTH  = 28,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   localparam int LAST = STAGES - 1;

   initial begin
      if (STAGES < 2) $error("gpio_sc_sync_bank: STAGES must be at least 2");
      if (WIDTH < 1)  $error("gpio_sc_sync_bank: WIDTH must be positive");
   end

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [LAST:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[LAST-1:0], async_in[b]};
         end
         assign sync_out[b] = chain[LAST];
      end
   endgenerate

endmodule

// File: rtl/gpio_sc_out_bank.sv
module gpio_sc_out_bank
   import gpio_sc_pkg::*;
#(
   parameter int NUM_PINS = 28
) (
   input  logic                clk,
   input  logic                rst_n,
   input  wr_stb_t             stb,
   input  logic [NUM_PINS-1:0] wdata,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] latch_q
);

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         logic set_hit, clr_hit;

         // Set and clear only act on pins that are outputs at write time.
         assign set_hit = stb.set && wdata[p] && dir_q[p];
         assign clr_hit = stb.clr && wdata[p] && dir_q[p];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       dir_q[p] <= 1'b0;
            else if (stb.dir) dir_q[p] <= wdata[p];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       latch_q[p] <= 1'b0;
            else if (set_hit) latch_q[p] <= 1'b1;
            else if (clr_hit) latch_q[p] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_sc_rd_mux.sv
module gpio_sc_rd_mux
   import gpio_sc_pkg::*;
#(
   parameter int NUM_PINS = 28,
   parameter int DATA_W   = 32
) (
   input  rd_sel_e             rsel,
   input  logic [NUM_PINS-1:0] level,
   input  logic [NUM_PINS-1:0] dir,
   output logic [DATA_W-1:0]   rdata
);

   localparam int PAD_W = DATA_W - NUM_PINS;

   logic [NUM_PINS-1:0] pick;

   always_comb begin
      unique case (rsel)
         RSEL_LEVEL: pick = level;
         RSEL_DIR:   pick = dir;
         default:    pick = '0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata = {{PAD_W{1'b0}}, pick};
      end else begin : g_full
         assign rdata = pick;
      end
   endgenerate

endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
   import gpio_sc_pkg::*;
#(
   parameter int NUM_PINS    = 28,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);

   initial begin
      if (NUM_PINS > DATA_W) $error("gpio_setclr_ctrl: NUM_PINS exceeds DATA_W");
      if (ADDR_W < 4)        $error("gpio_setclr_ctrl: ADDR_W must be at least 4");
   end

   wr_stb_t             stb;
   rd_sel_e             rsel;
   logic [NUM_PINS-1:0] level_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] latch_q;

   gpio_sc_decode #(.ADDR_W(ADDR_W)) i_decode (
      .addr (reg_addr),
      .wr   (reg_wr),
      .stb  (stb),
      .rsel (rsel)
   );

   gpio_sc_out_bank #(.NUM_PINS(NUM_PINS)) i_out_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (stb),
      .wdata   (reg_wdata[NUM_PINS-1:0]),
      .dir_q   (dir_q),
      .latch_q (latch_q)
   );

   gpio_sc_sync_bank #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (level_q)
   );

   gpio_sc_rd_mux #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) i_rd_mux (
      .rsel  (rsel),
      .level (level_q),
      .dir   (dir_q),
      .rdata (reg_rdata)
   );

   assign pin_out = latch_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_setclr_ctrl_chk.sv
module gpio_setclr_ctrl_chk
   import gpio_sc_pkg::*;
#(
   parameter int NUM_PINS = 28,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                reg_wr,
   input logic [DATA_W-1:0]   reg_wdata,
   input logic [DATA_W-1:0]   reg_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe
);

   logic                is_set, is_clr, is_dir;
   logic [NUM_PINS-1:0] act_mask;

   assign is_set   = reg_wr && (reg_addr == ADDR_W'(OFS_SET));
   assign is_clr   = reg_wr && (reg_addr == ADDR_W'(OFS_CLR));
   assign is_dir   = reg_wr && (reg_addr == ADDR_W'(OFS_DIR));
   assign act_mask = reg_wdata[NUM_PINS-1:0] & pin_oe;

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0 && pin_out == '0));

   // R2
   dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_dir |=> $stable(pin_oe));

   // R3
   set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_set |=> ((pin_out & $past(act_mask)) == $past(act_mask)));

   // R4
   clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_clr |=> ((pin_out & $past(act_mask)) == '0));

   // R6
   input_pins_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_set || is_clr) |=> ((pin_out & ~$past(pin_oe)) == ($past(pin_out) & ~$past(pin_oe))));

   // R7
   rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:NUM_PINS] == '0);

endmodule

bind gpio_setclr_ctrl gpio_setclr_ctrl_chk #(
   .NUM_PINS (NUM_PINS),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/test_gpio_setclr_ctrl.sv
`timescale 1ns/1ps
module test_gpio_setclr_ctrl;

   localparam int NP = 28;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int NV = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2.5 clk = ~clk;

   gpio_setclr_ctrl i_gpio_setclr_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   // {req, addr, wdata, expected pin_out, expected pin_oe}
   localparam logic [99:0] VEC [NV] = '{
      {8'd2,  4'h4, 32'h0000_00FF, 28'h000_0000, 28'h000_00FF}, // R2 pins 7..0 outputs
      {8'd6,  4'h8, 32'h0000_0F0F, 28'h000_000F, 28'h000_00FF}, // R6 bits 11..8 are inputs
      {8'd4,  4'hC, 32'h0000_0003, 28'h000_000C, 28'h000_00FF}, // R4
      {8'd5,  4'h8, 32'h0000_0000, 28'h000_000C, 28'h000_00FF}, // R5 zero set
      {8'd5,  4'hC, 32'h0000_0000, 28'h000_000C, 28'h000_00FF}, // R5 zero clear
      {8'd7,  4'h4, 32'hF000_0F00, 28'h000_000C, 28'h000_0F00}, // R7 upper dir bits dropped
      {8'd6,  4'h8, 32'hFFFF_FFFF, 28'h000_0F0C, 28'h000_0F00}, // R6 inputs keep latch
      {8'd9,  4'h4, 32'h0FFF_FFFF, 28'h000_0F0C, 28'hFFF_FFFF}, // R9 latch shows on switch
      {8'd4,  4'hC, 32'hF000_0F0C, 28'h000_0000, 28'hFFF_FFFF}, // R4 with R7 upper bits
      {8'd3,  4'h8, 32'h0AAA_AAAA, 28'hAAA_AAAA, 28'hFFF_FFFF}, // R3
      {8'd11, 4'h1, 32'hFFFF_FFFF, 28'hAAA_AAAA, 28'hFFF_FFFF}, // R11 unused offset
      {8'd5,  4'hC, 32'h0555_5555, 28'hAAA_AAAA, 28'hFFF_FFFF}  // R5 only zero bits hit
   };

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic reg_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] rd;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 oe in reset", DW'(pin_oe), '0);
      check("R1 out in reset", DW'(pin_out), '0);
      rst_n = 1'b1;
      @(negedge clk);
      reg_read(4'h4, rd);
      check("R1 dir after reset", rd, '0);

      for (int i = 0; i < NV; i++) begin
         logic [7:0]    rq;
         logic [3:0]    va;
         logic [31:0]   vd;
         logic [27:0]   eo, ee;
         {rq, va, vd, eo, ee} = VEC[i];
         reg_write(va, vd);
         check($sformatf("R%0d out vec%0d", rq, i), DW'(pin_out), DW'(eo));
         check($sformatf("R%0d oe vec%0d", rq, i), DW'(pin_oe), DW'(ee));
      end

      // R2 and R7: readback of direction, reserved bits zero
      reg_read(4'h4, rd);
      check("R2 dir readback", rd, 32'h0FFF_FFFF);
      // R10: write-only offsets read zero
      reg_read(4'h8, rd);
      check("R10 set read", rd, '0);
      reg_read(4'hC, rd);
      check("R10 clr read", rd, '0);
      // R11: unused offset reads zero
      reg_read(4'h3, rd);
      check("R11 unused read", rd, '0);

      // R8: synchronizer latency of exactly two edges
      @(negedge clk);
      pin_in = 28'h123_4567;
      reg_addr = 4'h0;
      @(negedge clk);
      reg_read(4'h0, rd);
      check("R8 one edge still old", rd, '0);
      @(negedge clk);
      reg_read(4'h0, rd);
      check("R8 two edges new", rd, 32'h0123_4567);

      // R8: conflict on outputs driven AAA.. while pads read 555..
      pin_in = 28'h555_5555;
      repeat (2) @(negedge clk);
      reg_read(4'h0, rd);
      check("R8 conflict level", rd, 32'h0555_5555);
      check("R8 drive unchanged", DW'(pin_out), 32'h0AAA_AAAA);

      // R1: reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      check("R1 oe after reset", DW'(pin_oe), '0);
      check("R1 out after reset", DW'(pin_out), '0);
      reg_read(4'h0, rd);
      check("R1 level after reset", rd, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule